// File: doc/BRIEF.md
# Three-Channel Ladder DAC Register Interface

This block is the bus-facing control for a bank of three independent 8-bit resistor-ladder D-A channels. A simple memory-mapped byte bus writes and reads a code register for each channel. It also reaches a control register that holds one output-enable per channel, a reference register whose bit 6 connects or disconnects the shared ladder from the reference voltage, and a read-only status byte. Each channel drives an 8-bit code toward the analog ladder, and the ladder output is modelled by that code n, which stands for VREF·n/256. Each channel also drives an enable toward the pin multiplexer. While a channel's enable is high, the multiplexer hands the shared pin to the DAC and no other function (port I/O, analog input, serial I/O, external interrupt) may use it.

Reconnecting the reference after it was cut off needs time before the ladder output is valid. The block counts this settle interval in clock cycles, with the count taken from the clock frequency and the required settle time. It reports readiness on a port and in the status byte. A channel's output is declared valid only when the channel is enabled and the reference is connected and settled. At all other times its code output is forced to zero.

Top module: `dacbank_top`

## Requirements
- R1: After reset, all channel codes, the control register and all channel outputs are 0. The reference register reads 0x40, meaning disconnected, refConnect is 0 and refReady is 0.
- R2: A byte written to address 0x98, 0x99 or 0x9A is stored as the code of channel 0, 1 or 2 and reads back unchanged from the same address.
- R3: In the control register at 0x96, bit 0, bit 1 and bit 2 drive chanEnable[0], chanEnable[1] and chanEnable[2] from the cycle after the write. Bits 3 to 7 are stored and read back, and they have no effect on any output.
- R4: Bit 6 of the reference register at 0x1F sets refConnect to its inverse, where 1 means disconnected. The other seven bits are stored and read back, and they have no effect.
- R5: When bit 6 is written 0 while it holds 1, refReady and status bit 0 (address 0x97, bits 7 to 1 read 0) stay 0 for SETTLE_CYCLES cycles after the write edge and become 1 at the SETTLE_CYCLES-th edge after it.
- R6: refReady is 0 whenever bit 6 is 1. Writing bit 6 to 1 during the settle interval cancels it. Writing 0 while the reference is already connected leaves refReady unchanged.
- R7: chanValid[i] is 1 exactly when chanEnable[i] is 1 and refReady is 1. chanCode for channel i (bits 8i+7..8i) equals that channel's code while chanValid[i] is 1, and is 0 otherwise.
- R8: Writes to any address other than 0x1F, 0x96 and 0x98 to 0x9A change no register and no output. Reads of unmapped addresses return 0, and reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address for reads and writes |
| busWrEn | input | 1 | Write strobe, one byte per cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| chanCode | output | 24 | Modelled ladder code per channel, channel 0 in the low byte |
| chanEnable | output | 3 | Pin takeover per channel toward the multiplexer |
| chanValid | output | 3 | Channel output enabled and reference settled |
| refConnect | output | 1 | Ladder connected to the reference |
| refReady | output | 1 | Reference connected and settle interval over |

## Verification
A wrong settle counter shows up at the ports, on refReady, within SETTLE_CYCLES cycles of a reconnect. It appears either as readiness arriving one edge early or late, or as a cancelled interval that still completes. Because every chanValid and every chanCode byte is gated by readiness, the same fault also zeroes or leaks channel codes in that window. A wrong decode or a corrupted register shows on the next readback or on chanEnable one cycle after the write that caused it. The bench compares each of these against values worked out from the requirements.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int NUM_CH   = 3;
  localparam int DATA_W   = 8;
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_DATA,
    RD_REF,
    RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic                ctrlWr;
    logic                refWr;
    logic [NUM_CH-1:0]   dataWr;
    rdSel_e              rdSel;
    logic [CH_IDX_W-1:0] rdCh;
  } dacStrobe_t;
endpackage

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
  import dacbank_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h96,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h97,
  parameter logic [ADDR_W-1:0] DATA_BASE = 8'h98,
  parameter logic [ADDR_W-1:0] REF_ADDR  = 8'h1F,
  parameter int REF_BIT       = 6,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              refDisc,
  output dacStrobe_t        strobe,
  output logic              refReady
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] settleCnt;
  logic             reconnect;
  logic             disconnectWr;

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    if (busAddr == CTRL_ADDR) begin
      strobe.rdSel  = RD_CTRL;
      strobe.ctrlWr = busWrEn;
    end else if (busAddr == STAT_ADDR) begin
      strobe.rdSel = RD_STAT;
    end else if (busAddr == REF_ADDR) begin
      strobe.rdSel = RD_REF;
      strobe.refWr = busWrEn;
    end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (busAddr == ADDR_W'(DATA_BASE + ADDR_W'(ch))) begin
        strobe.rdSel      = RD_DATA;
        strobe.rdCh       = CH_IDX_W'(ch);
        strobe.dataWr[ch] = busWrEn;
      end
    end
  end

  assign reconnect    = strobe.refWr & refDisc & ~busWrData[REF_BIT];
  assign disconnectWr = strobe.refWr & busWrData[REF_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (disconnectWr) begin
      settleCnt <= '0;
    end else if (reconnect) begin
      settleCnt <= CNT_LOAD;
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  assign refReady = ~refDisc & (settleCnt == '0);

  // R6: readiness never coexists with a disconnected reference
  p_ready_needs_connect_r6: assert property (@(posedge clk) disable iff (!rstN)
    refReady |-> !refDisc);

  // R5: a reconnect always opens a not-ready window
  p_reconnect_not_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    reconnect |=> !refReady);

  // R6: a disconnect write drops readiness on the next cycle
  p_disconnect_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    disconnectWr |=> !refReady);

  // R5: the counter never exceeds its load value
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    settleCnt <= CNT_LOAD);
endmodule

// File: rtl/dacbank_datapath.sv
module dacbank_datapath
  import dacbank_pkg::*;
#(
  parameter int REF_BIT = 6,
  parameter logic [DATA_W-1:0] REF_RESET = 8'h40
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dacStrobe_t               strobe,
  input  logic [DATA_W-1:0]        busWrData,
  input  logic                     refReady,
  output logic [DATA_W-1:0]        busRdData,
  output logic [NUM_CH*DATA_W-1:0] chanCode,
  output logic [NUM_CH-1:0]        chanEnable,
  output logic [NUM_CH-1:0]        chanValid,
  output logic                     refDisc
);
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] refReg;
  logic [DATA_W-1:0] codeReg [NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      refReg  <= REF_RESET;
    end else begin
      if (strobe.ctrlWr) ctrlReg <= busWrData;
      if (strobe.refWr)  refReg  <= busWrData;
    end
  end

  assign refDisc = refReg[REF_BIT];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  codeReg[ch] <= '0;
      else if (strobe.dataWr[ch]) codeReg[ch] <= busWrData;
    end

    assign chanEnable[ch] = ctrlReg[ch];
    assign chanValid[ch]  = ctrlReg[ch] & refReady;
    assign chanCode[ch*DATA_W +: DATA_W] = chanValid[ch] ? codeReg[ch] : '0;

    // R7: an invalid channel never leaks its code to the ladder
    p_code_zero_invalid_r7: assert property (@(posedge clk) disable iff (!rstN)
      !chanValid[ch] |-> chanCode[ch*DATA_W +: DATA_W] == '0);

    // R7: validity requires both the pin enable and the settled reference
    p_valid_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
      chanValid[ch] |-> (chanEnable[ch] && !refDisc));

    // R2: the code only moves on its own data strobe
    p_code_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.dataWr[ch] |=> $stable(codeReg[ch]));
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_CTRL: busRdData = ctrlReg;
      RD_REF:  busRdData = refReg;
      RD_DATA: busRdData = codeReg[strobe.rdCh];
      RD_STAT: busRdData = {{(DATA_W-1){1'b0}}, refReady};
      default: busRdData = '0;
    endcase
  end

  // R8: only one register is written per cycle
  p_one_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ctrlWr, strobe.refWr, strobe.dataWr}));
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
  import dacbank_pkg::*;
#(
  parameter int CLK_MHZ   = 16,
  parameter int SETTLE_US = 1,
  parameter int ADDR_W    = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [DATA_W-1:0]        busWrData,
  output logic [DATA_W-1:0]        busRdData,
  output logic [NUM_CH*DATA_W-1:0] chanCode,
  output logic [NUM_CH-1:0]        chanEnable,
  output logic [NUM_CH-1:0]        chanValid,
  output logic                     refConnect,
  output logic                     refReady
);
  localparam int SETTLE_CYCLES = CLK_MHZ * SETTLE_US;
  localparam int REF_BIT       = 6;

  dacStrobe_t strobe;
  logic       refDisc;

  dacbank_ctrl #(
    .ADDR_W        (ADDR_W),
    .CTRL_ADDR     (ADDR_W'('h96)),
    .STAT_ADDR     (ADDR_W'('h97)),
    .DATA_BASE     (ADDR_W'('h98)),
    .REF_ADDR      (ADDR_W'('h1F)),
    .REF_BIT       (REF_BIT),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .refDisc   (refDisc),
    .strobe    (strobe),
    .refReady  (refReady)
  );

  dacbank_datapath #(
    .REF_BIT   (REF_BIT),
    .REF_RESET (DATA_W'('h40))
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWrData  (busWrData),
    .refReady   (refReady),
    .busRdData  (busRdData),
    .chanCode   (chanCode),
    .chanEnable (chanEnable),
    .chanValid  (chanValid),
    .refDisc    (refDisc)
  );

  assign refConnect = ~refDisc;

  // R4: the connect output follows only a write to the reference register
  p_connect_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.refWr |=> $stable(refConnect));

  // R3: pin enables change only on a control write
  p_enable_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ctrlWr |=> $stable(chanEnable));
endmodule

// File: tb/test_dacbank_top.sv
module test_dacbank_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 16;
  localparam int NVEC       = 8;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] expRd;
    logic [2:0] expEn;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h98, 8'h11, 8'h11, 3'b000},
    '{8'h99, 8'hA5, 8'hA5, 3'b000},
    '{8'h9A, 8'hFF, 8'hFF, 3'b000},
    '{8'h96, 8'h05, 8'h05, 3'b101},
    '{8'h96, 8'hFA, 8'hFA, 3'b010},
    '{8'h96, 8'h00, 8'h00, 3'b000},
    '{8'h1F, 8'h7F, 8'h7F, 3'b000},
    '{8'h1F, 8'h40, 8'h40, 3'b000}
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  busAddr = 0;
  logic        busWrEn = 0;
  logic [7:0]  busWrData = 0;
  logic [7:0]  busRdData;
  logic [23:0] chanCode;
  logic [2:0]  chanEnable;
  logic [2:0]  chanValid;
  logic        refConnect;
  logic        refReady;
  int          nRun = 0;
  int          nFail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacbank_top i_dacbank_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .chanCode(chanCode),
    .chanEnable(chanEnable), .chanValid(chanValid),
    .refConnect(refConnect), .refReady(refReady)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rdCheck(string req, logic [7:0] a, logic [7:0] exp);
    busAddr = a;
    #1;
    check(req, busRdData, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 code", chanCode, 0);
    check("R1 enable", chanEnable, 0);
    check("R1 valid", chanValid, 0);
    check("R1 connect", refConnect, 0);
    check("R1 ready", refReady, 0);
    rdCheck("R1 ref", 8'h1F, 8'h40);
    rdCheck("R1 ctrl", 8'h96, 8'h00);
    rdCheck("R1 data0", 8'h98, 8'h00);
    rstN = 1;
    @(negedge clk);

    // R2 R3 R4 vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rdCheck("R2/R3/R4 readback", VECS[i].addr, VECS[i].expRd);
      check("R3 enable", chanEnable, VECS[i].expEn);
      check("R4 connect", refConnect, 0);
      check("R3/R4 no-effect code", chanCode, 0);
    end
    rdCheck("R2 data1 hold", 8'h99, 8'hA5);

    // R7 enabled but disconnected
    wr(8'h96, 8'h07);
    check("R7 valid disc", chanValid, 3'b000);
    check("R7 code disc", chanCode, 0);

    // R5 settle interval
    wr(8'h1F, 8'h00);
    check("R4 connect", refConnect, 1);
    for (int k = 1; k < SETTLE; k++) begin
      check("R5 not ready", refReady, 0);
      @(negedge clk);
    end
    check("R5 last not ready", refReady, 0);
    rdCheck("R5 status low", 8'h97, 8'h00);
    @(negedge clk);
    check("R5 ready", refReady, 1);
    rdCheck("R5 status high", 8'h97, 8'h01);
    check("R7 valid", chanValid, 3'b111);
    check("R7 code", chanCode, 24'hFFA511);

    // R6 rewriting 0 while connected keeps ready
    wr(8'h1F, 8'h00);
    check("R6 no restart", refReady, 1);
    wr(8'h99, 8'h3C);
    check("R7 code update", chanCode, 24'hFF3C11);
    wr(8'h96, 8'h02);
    check("R7 partial enable", chanCode, 24'h003C00);
    check("R7 partial valid", chanValid, 3'b010);

    // R8 unmapped writes and reads
    wr(8'h97, 8'hFF);
    wr(8'h9B, 8'h55);
    wr(8'h00, 8'hAA);
    wr(8'h95, 8'h07);
    rdCheck("R8 ctrl kept", 8'h96, 8'h02);
    rdCheck("R8 d0 kept", 8'h98, 8'h11);
    rdCheck("R8 d1 kept", 8'h99, 8'h3C);
    rdCheck("R8 d2 kept", 8'h9A, 8'hFF);
    rdCheck("R8 ref kept", 8'h1F, 8'h00);
    rdCheck("R8 unmapped read", 8'h9B, 8'h00);
    check("R8 outputs kept", chanCode, 24'h003C00);

    // R6 disconnect and cancel
    wr(8'h1F, 8'h40);
    check("R6 ready drop", refReady, 0);
    check("R7 code drop", chanCode, 0);
    wr(8'h1F, 8'h00);
    repeat (4) @(negedge clk);
    wr(8'h1F, 8'h40);
    repeat (SETTLE + 2) @(negedge clk);
    check("R6 cancel", refReady, 0);
    wr(8'h1F, 8'h00);
    repeat (SETTLE) @(negedge clk);
    check("R5 resettle", refReady, 1);

    // R1 reset mid-operation
    rstN = 0;
    #1;
    check("R1 rerst code", chanCode, 0);
    check("R1 rerst enable", chanEnable, 0);
    check("R1 rerst ready", refReady, 0);
    rdCheck("R1 rerst data1", 8'h99, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule